// File: doc/BRIEF.md
# Two-Bank Level Interrupt Aggregator

This block collects level-sensitive interrupt requests from peripherals and folds them into one interrupt line for the processor. Peripheral requests arrive on 64 lines, arranged as two banks of 32. A further small group of common and processor-local requests arrives on its own 8-line input. Each bank and the small group has its own enable mask. A line counts toward the processor interrupt only while its enable bit is set. Lines 0 to 3 of the first bank are meant for the four match outputs of a free-running system timer. Logically they are ordinary lines.

Software reaches the block through a word-addressed register port. Enables are changed only through a set/clear pair of registers. A write of 1 to the set register turns a line on. A write of 1 to the clear register turns it off. Zero bits written to either register leave the mask alone, so two software agents can edit one mask without a read-modify-write race. Each bank has a pending register that shows the enabled lines that are currently asserted. The basic pending register also carries one summary bit per peripheral bank, so one read finds the bank to look at next. The controller never clears a request itself. A pending bit stays up until the peripheral that raised it is serviced and drops its line.

Top module: `banked_irq_ctrl`

## Requirements
- R1: While reset is high and on the first cycles after it, every enable mask is zero, `irq_o` is 0 and `reg_rdata_o` is 0.
- R2: Word offsets are: 0 and 1 bank pending (RO), 2 basic pending (RO), 3/4/5 enable-set for bank 0/bank 1/basic, 6/7/8 enable-clear for the same three. A read of a set or clear offset returns that mask. Any other offset reads 0, and writes to it change nothing.
- R3: A write to an enable-set offset sets each mask bit whose data bit is 1. Bits written 0 keep their value.
- R4: A write to an enable-clear offset clears each mask bit whose data bit is 1. Bits written 0 keep their value.
- R5: Bit n of pending offset 0 is line n AND its enable. Bit n of offset 1 is line 32+n AND its enable. Disabled lines read 0.
- R6: A pending bit follows its source level. Reading it does not clear it, and it falls only when the source line falls.
- R7: Several lines may be pending together, and all of them show in the same read.
- R8: `irq_o` is registered. It is 1 exactly one cycle after a cycle in which any enabled line in any bank or in the basic group was high, and 0 otherwise.
- R9: In the basic pending word, bits 7:0 are basic lines AND their enables. Bit 8 is 1 when any enabled bank-0 line is high. Bit 9 is the same for bank 1. Bits above 9 read 0.
- R10: `reg_rdata_o` loads on the clock edge at which `reg_rd_i` is high, using the state before that edge. On every other cycle it holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| periph_irq_i | input | 64 | Peripheral request levels; bits 31:0 are bank 0, bits 63:32 are bank 1 |
| basic_irq_i | input | 8 | Common and processor-local request levels |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 4 | Word offset |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | Registered processor interrupt request |

## Verification
The only internal state is the three enable masks. A wrong mask bit can be seen in two ways. The next read of any set or clear offset returns it. One cycle after its line is driven high, it also shows as a missing or spurious `irq_o` and pending bit. A model of those masks is kept beside the design and compared on every cycle. Random set, clear and source traffic then brings out a corrupted bit within a cycle of its first effect. Directed cases cover zero-bit writes, unmapped offsets, repeated reads of a held request and the bank summary bits.

// File: rtl/icu_pkg.sv
package icu_pkg;
  localparam int BANK_W    = 32;
  localparam int NUM_BANKS = 2;
  localparam int BASIC_W   = 8;
  localparam int ADDR_W    = 4;
  localparam int DATA_W    = 32;
  // register groups: one per bank plus the basic group
  localparam int NGRP      = NUM_BANKS + 1;
  localparam int PEND_BASE = 0;
  localparam int SET_BASE  = NGRP;
  localparam int CLR_BASE  = 2 * NGRP;
endpackage

// File: rtl/icu_enable_bank.sv
module icu_enable_bank #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         set_we,
  input  logic         clr_we,
  input  logic [W-1:0] mask_i,
  input  logic [W-1:0] src_i,
  output logic [W-1:0] en_o,
  output logic [W-1:0] pend_o
);
  logic [W-1:0] en_q;

  always_ff @(posedge clk) begin
    if (rst)         en_q <= '0;
    else if (set_we) en_q <= en_q | mask_i;
    else if (clr_we) en_q <= en_q & ~mask_i;
  end

  assign en_o   = en_q;
  assign pend_o = src_i & en_q;

  // R1
  en_reset_chk: assert property (@(posedge clk) $past(rst) |-> en_q == '0);

  // R3
  set_apply_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(set_we) && !$past(rst)) |-> ((en_q & $past(mask_i)) == $past(mask_i)));

  // R3
  set_keep_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(set_we) && !$past(rst)) |-> (($past(en_q) & ~en_q) == '0));

  // R4
  clr_apply_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(clr_we) && !$past(set_we) && !$past(rst)) |-> ((en_q & $past(mask_i)) == '0));

  // R4
  clr_keep_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(clr_we) && !$past(set_we) && !$past(rst)) |-> ((en_q & ~$past(en_q)) == '0));
endmodule

// File: rtl/icu_readmux.sv
module icu_readmux
  import icu_pkg::*;
#(
  parameter int NB = NUM_BANKS,
  parameter int BW = BANK_W,
  parameter int SW = BASIC_W,
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic [AW-1:0]    addr_i,
  input  logic [NB*BW-1:0] bank_pend_i,
  input  logic [NB*BW-1:0] bank_en_i,
  input  logic [SW-1:0]    basic_pend_i,
  input  logic [SW-1:0]    basic_en_i,
  output logic [DW-1:0]    data_o
);
  localparam int NG = NB + 1;
  localparam int SB = NG;
  localparam int CB = 2 * NG;

  logic [DW-1:0] basic_word;

  always_comb begin
    basic_word = '0;
    basic_word[SW-1:0] = basic_pend_i;
    for (int b = 0; b < NB; b++)
      basic_word[SW+b] = |bank_pend_i[b*BW +: BW];
  end

  always_comb begin
    data_o = '0;
    for (int b = 0; b < NB; b++) begin
      if (addr_i == AW'(b))
        data_o = DW'(bank_pend_i[b*BW +: BW]);
      if (addr_i == AW'(SB + b) || addr_i == AW'(CB + b))
        data_o = DW'(bank_en_i[b*BW +: BW]);
    end
    if (addr_i == AW'(NB))
      data_o = basic_word;
    if (addr_i == AW'(SB + NB) || addr_i == AW'(CB + NB))
      data_o = DW'(basic_en_i);
  end
endmodule

// File: rtl/banked_irq_ctrl.sv
module banked_irq_ctrl
  import icu_pkg::*;
#(
  parameter int NB = NUM_BANKS,
  parameter int BW = BANK_W,
  parameter int SW = BASIC_W,
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NB*BW-1:0] periph_irq_i,
  input  logic [SW-1:0]    basic_irq_i,
  input  logic             reg_wr_i,
  input  logic             reg_rd_i,
  input  logic [AW-1:0]    reg_addr_i,
  input  logic [DW-1:0]    reg_wdata_i,
  output logic [DW-1:0]    reg_rdata_o,
  output logic             irq_o
);
  localparam int NG = NB + 1;
  localparam int SB = NG;
  localparam int CB = 2 * NG;

  logic [NB*BW-1:0] bank_en, bank_pend;
  logic [SW-1:0]    basic_en, basic_pend;
  logic [DW-1:0]    rd_word;
  logic             irq_q;
  logic [DW-1:0]    rdata_q;

  for (genvar b = 0; b < NB; b++) begin : g_bank
    icu_enable_bank #(.W(BW)) u_bank (
      .clk    (clk),
      .rst    (rst),
      .set_we (reg_wr_i && reg_addr_i == AW'(SB + b)),
      .clr_we (reg_wr_i && reg_addr_i == AW'(CB + b)),
      .mask_i (reg_wdata_i[BW-1:0]),
      .src_i  (periph_irq_i[b*BW +: BW]),
      .en_o   (bank_en[b*BW +: BW]),
      .pend_o (bank_pend[b*BW +: BW])
    );
  end

  icu_enable_bank #(.W(SW)) u_basic (
    .clk    (clk),
    .rst    (rst),
    .set_we (reg_wr_i && reg_addr_i == AW'(SB + NB)),
    .clr_we (reg_wr_i && reg_addr_i == AW'(CB + NB)),
    .mask_i (reg_wdata_i[SW-1:0]),
    .src_i  (basic_irq_i),
    .en_o   (basic_en),
    .pend_o (basic_pend)
  );

  icu_readmux #(.NB(NB), .BW(BW), .SW(SW), .AW(AW), .DW(DW)) u_rmux (
    .addr_i       (reg_addr_i),
    .bank_pend_i  (bank_pend),
    .bank_en_i    (bank_en),
    .basic_pend_i (basic_pend),
    .basic_en_i   (basic_en),
    .data_o       (rd_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      irq_q <= (|bank_pend) | (|basic_pend);
      if (reg_rd_i) rdata_q <= rd_word;
    end
  end

  assign irq_o       = irq_q;
  assign reg_rdata_o = rdata_q;

  // R8
  irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (($past(bank_en) == '0) && ($past(basic_en) == '0)) |-> !irq_o);

  // R8
  irq_src_low_chk: assert property (@(posedge clk) disable iff (rst)
    (($past(periph_irq_i) == '0) && ($past(basic_irq_i) == '0)) |-> !irq_o);

  // R10
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(reg_rd_i) && !$past(rst)) |-> $stable(reg_rdata_o));

  // R1
  out_reset_chk: assert property (@(posedge clk)
    $past(rst) |-> (!irq_o && reg_rdata_o == '0));
endmodule

// File: tb/sim_banked_irq_ctrl.sv
module sim_banked_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] src = '0;
  logic [7:0]  bsrc = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wd = '0;
  logic [31:0] rdata;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk; // 125 MHz

  banked_irq_ctrl u0 (
    .clk(clk), .rst(rst), .periph_irq_i(src), .basic_irq_i(bsrc),
    .reg_wr_i(wr), .reg_rd_i(rd), .reg_addr_i(addr), .reg_wdata_i(wd),
    .reg_rdata_o(rdata), .irq_o(irq)
  );

  // behavioural reference
  logic [31:0] m_en0, m_en1, m_rd;
  logic [7:0]  m_enb;
  logic        m_irq;
  logic [3:0]  m_last_addr;

  function automatic logic [31:0] ref_read(input logic [3:0] a);
    logic [31:0] p0, p1, pb;
    p0 = src[31:0] & m_en0;
    p1 = src[63:32] & m_en1;
    pb = {22'd0, |p1, |p0, bsrc & m_enb};
    case (a)
      4'd0: return p0;
      4'd1: return p1;
      4'd2: return pb;
      4'd3, 4'd6: return m_en0;
      4'd4, 4'd7: return m_en1;
      4'd5, 4'd8: return {24'd0, m_enb};
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_en0 <= '0; m_en1 <= '0; m_enb <= '0; m_irq <= 1'b0; m_rd <= '0;
      m_last_addr <= 4'd15;
    end else begin
      m_irq <= |(src[31:0] & m_en0) || |(src[63:32] & m_en1) || |(bsrc & m_enb);
      if (wr) begin
        case (addr)
          4'd3: m_en0 <= m_en0 | wd;
          4'd4: m_en1 <= m_en1 | wd;
          4'd5: m_enb <= m_enb | wd[7:0];
          4'd6: m_en0 <= m_en0 & ~wd;
          4'd7: m_en1 <= m_en1 & ~wd;
          4'd8: m_enb <= m_enb & ~wd[7:0];
          default: ;
        endcase
      end
      if (rd) begin
        m_rd <= ref_read(addr);
        m_last_addr <= addr;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic string rd_tag(input logic [3:0] a);
    if (a <= 4'd1) return "R5";
    if (a == 4'd2) return "R9";
    if (a >= 4'd3 && a <= 4'd5) return "R3";
    if (a >= 4'd6 && a <= 4'd8) return "R4";
    return "R2";
  endfunction

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      chk("R8 irq", {31'd0, irq}, {31'd0, m_irq});
      chk({rd_tag(m_last_addr), " R10 rdata"}, rdata, m_rd);
    end
  end

  task automatic op(input logic w, input logic r, input logic [3:0] a, input logic [31:0] d);
    wr = w; rd = r; addr = a; wd = d;
    @(negedge clk);
    wr = 1'b0; rd = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [3:0] a, input logic [31:0] exp);
    op(1'b0, 1'b1, a, 32'd0);
    chk(tag, rdata, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs during reset
    chk("R1 irq in reset", {31'd0, irq}, 32'd0);
    chk("R1 rdata in reset", rdata, 32'd0);
    rst = 1'b0;
    rd_chk("R1 bank0 mask after reset", 4'd3, 32'd0);
    rd_chk("R1 basic mask after reset", 4'd5, 32'd0);

    // R3: set with 1s, zeros keep
    op(1'b1, 1'b0, 4'd3, 32'h0000_000A);
    rd_chk("R3 set bits", 4'd3, 32'h0000_000A);
    op(1'b1, 1'b0, 4'd3, 32'h0);
    rd_chk("R3 zero write keeps", 4'd3, 32'h0000_000A);
    op(1'b1, 1'b0, 4'd3, 32'h1);
    rd_chk("R3 add bit", 4'd3, 32'h0000_000B);

    // R4: clear with 1s, zeros keep
    op(1'b1, 1'b0, 4'd6, 32'h2);
    rd_chk("R4 clear bit", 4'd3, 32'h0000_0009);
    op(1'b1, 1'b0, 4'd6, 32'h0);
    rd_chk("R4 zero write keeps", 4'd6, 32'h0000_0009);

    // R5 R7 R8: timer lines 0..3 raised, lines 0 and 3 enabled
    src[3:0] = 4'hF;
    @(negedge clk);
    chk("R8 irq after enabled line", {31'd0, irq}, 32'd1);
    rd_chk("R7 multiple pending", 4'd0, 32'h0000_0009);

    // R6: read does not clear; follows source
    rd_chk("R6 pending held after read", 4'd0, 32'h0000_0009);
    src[0] = 1'b0;
    rd_chk("R6 pending drops with source", 4'd0, 32'h0000_0008);
    src[3:0] = 4'h0;
    @(negedge clk);
    chk("R8 irq low after sources drop", {31'd0, irq}, 32'd0);
    rd_chk("R6 pending clear", 4'd0, 32'h0);

    // R5 R9: bank 1 and basic group
    op(1'b1, 1'b0, 4'd4, 32'h8000_0000);
    src[63] = 1'b1;
    rd_chk("R5 bank1 pending", 4'd1, 32'h8000_0000);
    rd_chk("R9 bank1 summary", 4'd2, 32'h0000_0200);
    op(1'b1, 1'b0, 4'd5, 32'h0000_0001);
    bsrc = 8'h03;
    rd_chk("R9 basic pending", 4'd2, 32'h0000_0201);
    src[63] = 1'b0;
    bsrc = 8'h00;

    // R2: unmapped offset
    op(1'b1, 1'b0, 4'd12, 32'hFFFF_FFFF);
    rd_chk("R2 unmapped reads 0", 4'd12, 32'h0);
    rd_chk("R2 unmapped write ignored", 4'd3, 32'h0000_0009);

    // R10: rdata holds without read
    op(1'b0, 1'b0, 4'd0, 32'h0);
    chk("R10 rdata held", rdata, 32'h0000_0009);

    // R8: disabled line alone raises nothing
    src[5] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R8 disabled line no irq", {31'd0, irq}, 32'd0);
    rd_chk("R5 disabled line reads 0", 4'd0, 32'h0);
    src[5] = 1'b0;

    // random traffic, compared cycle by cycle
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 3) == 0) begin
        src  = {$urandom() & $urandom(), $urandom() & $urandom()};
        bsrc = 8'($urandom());
      end
      op($urandom_range(0, 2) == 0, $urandom_range(0, 1) == 1,
         4'($urandom_range(0, 15)), $urandom() & $urandom());
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog R1 actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule